// File: doc/BRIEF.md
# Embedded-Boundary Serial Word Deserializer

This block rebuilds 24-bit parallel words from a two-wire serial link made of a data line and a bit clock. The transmitter marks the end of every word by leaving the bit clock high for a stretched interval instead of pulsing it low, and during that interval it places two extra bits on the data line. The first extra bit is the complement of the last data bit and the second equals it. The data line therefore always toggles while the clock is held high.

Both serial lines are synchronized into a faster system clock. Each rising edge of the synchronized bit clock shifts one data bit into the word register. A counter measures how long the clock stays high. When that time exceeds twice the nominal half-bit length, the block treats the interval as a word boundary. It samples the two extra bits at the middle of their bit slots. When the clock falls at the end of the boundary, it latches the 24 data bits and checks the two extra bits. The extra bits are never forwarded.

The captured word is held on a bidirectional parallel port. The port is driven only while the direction input is low. A single-cycle valid pulse and a frame-error flag accompany each word.

Top module: `ebd_deser`

## Requirements
- R1: After reset `valid_o` and `frame_err_o` are 0 and the held word is 0. No valid pulse occurs until the first boundary interval has ended.
- R2: Data bits arrive least significant bit first. The bit sampled at the 1st rising clock edge of a frame appears on `par_io[0]` and the bit at the 24th edge appears on `par_io[23]`.
- R3: `valid_o` pulses high for exactly one system cycle for each boundary interval. The held word and flag change in that same cycle.
- R4: A clock-high interval of at most 2*HALF_BIT system cycles is an ordinary bit and never produces a capture. The capture happens only after the falling clock edge that ends a high interval longer than that.
- R5: `frame_err_o` is 1 for a word whose first boundary bit equals data bit 24, or whose second boundary bit differs from data bit 24. It is 0 when the first boundary bit is the complement of bit 24 and the second equals bit 24. The word itself is delivered in either case.
- R6: Between valid pulses the held word and `frame_err_o` keep their values.
- R7: With `dir_i` = 1 the block leaves `par_io` undriven, so another driver sets its value. With `dir_i` = 0 the block drives the held word.
- R8: The first boundary bit is sampled 2*HALF_BIT cycles after the last data rising edge and the second boundary bit 4*HALF_BIT cycles after it. If the boundary ends before the second sample point, the word is delivered with `frame_err_o` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oversampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial bit clock, asynchronous |
| ser_dat_i | input | 1 | Serial data, asynchronous |
| dir_i | input | 1 | 0: drive parallel port, 1: release it |
| par_io | inout | 24 | Parallel word port |
| valid_o | output | 1 | One-cycle pulse per captured word |
| frame_err_o | output | 1 | Boundary-bit check failed for the held word |

## Verification
The hardest case to reach from the ports is a boundary that is long enough to count as a word end but ends before the second boundary-bit sample point. A word that is captured this way must still be flagged. The bench's serial transmitter model takes the stretch length as an argument, so it can emit both full-length boundaries and boundaries cut short to three half-bits. Error frames are produced by giving the model boundary bits that break the complement and equality rule. Before any boundary is sent, a stream of plain bit periods shows that ordinary clock-high intervals never cause a capture.

// File: rtl/ebd_pkg.sv
package ebd_pkg;

  typedef struct packed {
    logic rise;     // synchronized bit clock rose
    logic fall;     // synchronized bit clock fell
    logic samp_a;   // mid-slot of first boundary bit
    logic samp_b;   // mid-slot of second boundary bit
    logic bnd_end;  // falling edge closing a stretched high interval
  } ebd_strobe_t;

  function automatic logic boundary_bad(input logic last_bit, input logic bit_a,
                                        input logic bit_b, input logic got_a,
                                        input logic got_b);
    return !got_a || !got_b || (bit_a == last_bit) || (bit_b != last_bit);
  endfunction

endpackage

// File: rtl/ebd_sync.sv
module ebd_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        stage_q[s] <= '0;
      end else if (s == 0) begin
        stage_q[s] <= async_i;
      end else begin
        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/ebd_clk_mon.sv
module ebd_clk_mon
  import ebd_pkg::*;
#(
  parameter int HALF_BIT = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        sclk_i,
  output ebd_strobe_t stb_o
);

  localparam int CNT_MAX = 8 * HALF_BIT;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int LONG_TH = 2 * HALF_BIT;
  localparam int SAMP_A  = 2 * HALF_BIT;
  localparam int SAMP_B  = 4 * HALF_BIT;

  logic             sclk_d;
  logic [CNT_W-1:0] hi_cnt;
  logic             rise_w;
  logic             fall_w;

  assign rise_w = sclk_i & ~sclk_d;
  assign fall_w = ~sclk_i & sclk_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d <= 1'b0;
      hi_cnt <= '0;
    end else begin
      sclk_d <= sclk_i;
      if (rise_w) begin
        hi_cnt <= CNT_W'(1);
      end else if (sclk_i && hi_cnt != CNT_W'(CNT_MAX)) begin
        hi_cnt <= hi_cnt + 1'b1;
      end
    end
  end

  always_comb begin
    stb_o.rise    = rise_w;
    stb_o.fall    = fall_w;
    stb_o.samp_a  = sclk_i && !rise_w && (hi_cnt == CNT_W'(SAMP_A));
    stb_o.samp_b  = sclk_i && !rise_w && (hi_cnt == CNT_W'(SAMP_B));
    stb_o.bnd_end = fall_w && (hi_cnt > CNT_W'(LONG_TH));
  end

endmodule

// File: rtl/ebd_frame.sv
module ebd_frame
  import ebd_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  ebd_strobe_t       stb_i,
  input  logic              sdat_i,
  output logic [DATA_W-1:0] word_o,
  output logic              err_o,
  output logic              valid_o
);

  logic [DATA_W-1:0] shreg;
  logic              bit_a, bit_b;
  logic              got_a, got_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
      bit_a <= 1'b0;
      bit_b <= 1'b0;
      got_a <= 1'b0;
      got_b <= 1'b0;
    end else begin
      if (stb_i.rise) begin
        shreg <= {sdat_i, shreg[DATA_W-1:1]};
        got_a <= 1'b0;
        got_b <= 1'b0;
      end
      if (stb_i.samp_a) begin
        bit_a <= sdat_i;
        got_a <= 1'b1;
      end
      if (stb_i.samp_b) begin
        bit_b <= sdat_i;
        got_b <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word_o  <= '0;
      err_o   <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= stb_i.bnd_end;
      if (stb_i.bnd_end) begin
        word_o <= shreg;
        err_o  <= boundary_bad(shreg[DATA_W-1], bit_a, bit_b, got_a, got_b);
      end
    end
  end

endmodule

// File: rtl/ebd_deser.sv
module ebd_deser
  import ebd_pkg::*;
#(
  parameter int DATA_W      = 24,
  parameter int HALF_BIT    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_clk_i,
  input  logic              ser_dat_i,
  input  logic              dir_i,
  inout  wire  [DATA_W-1:0] par_io,
  output logic              valid_o,
  output logic              frame_err_o
);

  logic [1:0]        sync_w;
  ebd_strobe_t       stb;
  logic [DATA_W-1:0] word_q;
  logic              bnd_end;
  logic              clk_rise;
  logic              clk_fall;

  ebd_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) i_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i ({ser_dat_i, ser_clk_i}),
    .sync_o  (sync_w)
  );

  ebd_clk_mon #(.HALF_BIT(HALF_BIT)) i_mon (
    .clk    (clk),
    .rst    (rst),
    .sclk_i (sync_w[0]),
    .stb_o  (stb)
  );

  ebd_frame #(.DATA_W(DATA_W)) i_frame (
    .clk     (clk),
    .rst     (rst),
    .stb_i   (stb),
    .sdat_i  (sync_w[1]),
    .word_o  (word_q),
    .err_o   (frame_err_o),
    .valid_o (valid_o)
  );

  assign bnd_end  = stb.bnd_end;
  assign clk_rise = stb.rise;
  assign clk_fall = stb.fall;

  assign par_io = dir_i ? {DATA_W{1'bz}} : word_q;

endmodule

// File: rtl/ebd_deser_chk.sv
module ebd_deser_chk #(
  parameter int DATA_W = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              valid_o,
  input logic              frame_err_o,
  input logic [DATA_W-1:0] word_q,
  input logic              bnd_end,
  input logic              clk_rise,
  input logic              clk_fall
);

  p_valid_single_r3: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  p_cap_after_bnd_r4: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> $past(bnd_end));

  p_word_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> $stable(word_q));

  p_err_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> $stable(frame_err_o));

  p_edge_excl_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({clk_rise, clk_fall}));

  p_bnd_on_fall_r4: assert property (@(posedge clk) disable iff (rst)
    bnd_end |-> clk_fall);

endmodule

bind ebd_deser ebd_deser_chk #(.DATA_W(DATA_W)) i_chk (
  .clk         (clk),
  .rst         (rst),
  .valid_o     (valid_o),
  .frame_err_o (frame_err_o),
  .word_q      (word_q),
  .bnd_end     (bnd_end),
  .clk_rise    (clk_rise),
  .clk_fall    (clk_fall)
);

// File: tb/test_ebd_deser.sv
`timescale 1ns/1ps
module test_ebd_deser;

  localparam int W = 24;
  localparam int H = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_clk = 1'b0;
  logic ser_dat = 1'b0;
  logic dir = 1'b0;
  logic tb_en = 1'b0;
  logic [W-1:0] tb_drv = '0;
  wire  [W-1:0] bus;
  logic valid_o, frame_err_o;

  assign bus = tb_en ? tb_drv : {W{1'bz}};

  always #2 clk = ~clk;

  ebd_deser #(.DATA_W(W), .HALF_BIT(H), .SYNC_STAGES(2)) i_ebd_deser (
    .clk         (clk),
    .rst         (rst),
    .ser_clk_i   (ser_clk),
    .ser_dat_i   (ser_dat),
    .dir_i       (dir),
    .par_io      (bus),
    .valid_o     (valid_o),
    .frame_err_o (frame_err_o)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [W-1:0] got_w [64];
  logic         got_e [64];
  logic [W-1:0] exp_w [64];
  logic         exp_e [64];
  int n_got = 0;
  int n_exp = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && valid_o && !dir && n_got < 64) begin
      got_w[n_got] = bus;
      got_e[n_got] = frame_err_o;
      n_got++;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic plain_bit(input logic b);
    ser_dat = b; ser_clk = 1'b0; cyc(H);
    ser_clk = 1'b1; cyc(H);
  endtask

  // stretch: cycles of boundary after the last data bit's high half
  task automatic send_frame(input logic [W-1:0] w, input logic ba, input logic bb,
                            input int stretch);
    for (int k = 0; k < W; k++) plain_bit(w[k]);
    ser_dat = ba;
    cyc((stretch < 2*H) ? stretch : 2*H);
    if (stretch > 2*H) begin
      ser_dat = bb;
      cyc(stretch - 2*H);
    end
    ser_clk = 1'b0;
  endtask

  task automatic frame_exp(input logic [W-1:0] w, input logic ba, input logic bb,
                           input int stretch);
    logic e;
    send_frame(w, ba, bb, stretch);
    e = (ba == w[W-1]) || (bb != w[W-1]) || (stretch < 4*H);
    exp_w[n_exp] = w;
    exp_e[n_exp] = e;
    n_exp++;
  endtask

  task automatic good_frame(input logic [W-1:0] w);
    frame_exp(w, ~w[W-1], w[W-1], 4*H);
  endtask

  initial begin
    logic [W-1:0] held;
    cyc(6);
    rst = 1'b0;
    cyc(2);
    // R1: reset state
    chk("R1 valid after reset", valid_o, 0);
    chk("R1 err after reset", frame_err_o, 0);
    chk("R1 word after reset", bus, 0);

    // R1/R4: plain bit periods only, no boundary
    for (int i = 0; i < 40; i++) plain_bit(logic'((i * 7 + 3) % 5 > 1));
    ser_clk = 1'b0; cyc(3 * H);
    chk("R1 R4 no capture before boundary", n_got, 0);

    // R2: walking one across every data position
    for (int i = 0; i < W; i++) good_frame(W'(1) << i);
    good_frame(24'h3FFFFF);
    good_frame(24'h155555);
    good_frame(24'hAAAAAA);
    good_frame(24'h000000);
    good_frame(24'hFFFFFF);
    good_frame(24'hC3A50F);
    // R5: broken boundary bits
    frame_exp(24'h123456, 1'b0, 1'b0, 4*H);
    frame_exp(24'h923456, 1'b0, 1'b0, 4*H);
    frame_exp(24'h923456, 1'b1, 1'b0, 4*H);
    frame_exp(24'h0F0F0F, 1'b0, 1'b1, 4*H);
    // R8: boundary cut short before the second sample point
    frame_exp(24'h5A5A5A, 1'b1, 1'b0, 2*H);
    good_frame(24'h00BEEF);
    ser_clk = 1'b0; ser_dat = 1'b0;
    cyc(4 * H);

    chk("R3 one capture per boundary", n_got, n_exp);
    for (int i = 0; i < n_exp && i < n_got; i++) begin
      if (i < W) chk("R2 walking one bit order", got_w[i], exp_w[i]);
      else chk("R2 word value", got_w[i], exp_w[i]);
      if (i >= W + 6 && i < W + 10) chk("R5 frame error flag", got_e[i], exp_e[i]);
      else if (i == W + 10) chk("R8 short boundary flagged", got_e[i], exp_e[i]);
      else chk("R5 clean frame flag", got_e[i], exp_e[i]);
    end

    // R6: hold between pulses
    held = bus;
    cyc(25);
    chk("R6 word held", bus, held);
    chk("R6 err held", frame_err_o, 0);
    chk("R6 held is last word", held, 24'h00BEEF);

    // R7: released port
    dir = 1'b1; tb_en = 1'b1; tb_drv = 24'h6C6C93;
    cyc(2);
    chk("R7 port released when dir high", bus, 24'h6C6C93);
    tb_drv = 24'h000000;
    cyc(2);
    chk("R7 port follows other driver", bus, 24'h000000);
    tb_en = 1'b0; dir = 1'b0;
    cyc(2);
    chk("R7 port driven when dir low", bus, 24'h00BEEF);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule